// File: doc/BRIEF.md
# Multi-Channel DMA Control Register File

This block is the software-facing register file of a sixteen-channel DMA controller. A simple 32-bit register bus writes and reads a strided per-channel map holding, for each channel, a source address, a destination address and two control words. The stored fields drive the channel engines directly through flattened output buses. The engines are outside this block. They return a live current-count value, which appears inside control word 0 on reads. They also return a one-cycle completion pulse and a one-cycle unmask-event pulse per channel.

Two global write-one-to-clear status words collect those pulses. The completion word drives a single interrupt line. A global configuration word reports a hardware version and an encoded channel count, and it holds the round-robin arbitration select. Read data is combinational on the address, and writes take effect at the next rising clock edge.

Top module: `dma_regfile`

## Requirements
- R1: After reset, every per-channel word, both status words and the arbitration select are 0, and `irq` is 0.
- R2: Channel c occupies byte offsets c*0x10 to c*0x10+0xC. Word +0x0 is the source address, +0x4 the destination address, +0x8 control word 0 and +0xC control word 1. Source and destination store and read back all 32 bits and drive `ch_src_o`/`ch_dst_o` slice c.
- R3: In control word 0, bits 31:16 (transfer count) and bits 7:0 are writable: bit 7 source fixed, bit 6 destination fixed, bits 5:3 burst code, bit 2 done-interrupt enable, bit 1 channel enable, bit 0 hardware mode. Bits 15:8 read the live value of `eng_cur_cnt` slice c. Writes to bits 15:8 are ignored, and `ch_ctrl0_o` carries 0 there.
- R4: In control word 1, all bits 25:0 except bit 15 are writable. These hold segment 25:22, source request 21:16, continuous 14, destination request 13:8, next channel 7:3, coherent 2, fail 1 and mask 0. Bits 31:26 and 15 read 0.
- R5: The completion status word at 0x204 has bit c for channel c. Writing 1 to a bit clears it, and writing 0 to a bit leaves it unchanged.
- R6: A pulse on `eng_done[c]` sets completion bit c only if control word 0 bit 2 of channel c is 1.
- R7: `irq` is 1 exactly when at least one completion status bit is 1.
- R8: If a completion set and a write-1 clear hit the same bit in one cycle, the bit ends up set.
- R9: The unmask status word at 0x200 is set by `eng_unmask[c]` regardless of enables and is cleared by writing 1s. It has no effect on `irq`.
- R10: The configuration word at 0x220 reads bit 0 as the writable round-robin select (also on `arb_rr_o`), bits 2:1 as `HW_VER`, bits 4:3 as log2(NUM_CH/8), and all other bits as 0. Writes change only bit 0.
- R11: A pulse on `eng_done[c]` clears the enable bit (control word 0 bit 1) of channel c. A write to that control word in the same cycle takes priority over the clear.
- R12: Addresses outside the channel window (0x100 and above for 16 channels) other than 0x200, 0x204 and 0x220 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address for write and read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| eng_cur_cnt | input | NUM_CH*8 | Live current count per channel |
| eng_done | input | NUM_CH | Completion pulse per channel |
| eng_unmask | input | NUM_CH | Unmask-event pulse per channel |
| ch_src_o | output | NUM_CH*32 | Source address per channel |
| ch_dst_o | output | NUM_CH*32 | Destination address per channel |
| ch_ctrl0_o | output | NUM_CH*32 | Control word 0 per channel (count bits zero) |
| ch_ctrl1_o | output | NUM_CH*32 | Control word 1 per channel |
| arb_rr_o | output | 1 | Round-robin arbitration select |
| irq | output | 1 | Completion interrupt |

## Verification
Two collisions can happen in a single cycle. A completion pulse can meet a write-1 clear of the same status bit, and a completion pulse can meet a software write to the same channel's control word 0. The bench provokes both on purpose and also lets them arise from random traffic. A behavioural model updates on every edge with set-over-clear and write-over-done priority and is compared against every output and the read data on each cycle. Directed checks then confirm the surviving status bit and the surviving enable bit through register reads.

// File: rtl/dma_regfile_pkg.sv
package dma_regfile_pkg;
   localparam int DW = 32;
   localparam logic [DW-1:0] CTRL0_WMASK = 32'hFFFF_00FF;
   localparam logic [DW-1:0] CTRL1_WMASK = 32'h03FF_7FFF;
   localparam int CUR_LSB = 8;
   localparam int CUR_W   = 8;
   localparam int IE_BIT  = 2;
   localparam int EN_BIT  = 1;
   localparam int UNMASK_OFS = 'h200;
   localparam int DONE_OFS   = 'h204;
   localparam int CFG_OFS    = 'h220;

   typedef enum logic [1:0] {
      W_SRC  = 2'd0,
      W_DST  = 2'd1,
      W_CTL0 = 2'd2,
      W_CTL1 = 2'd3
   } ch_word_e;
endpackage

// File: rtl/dma_w1c_status.sv
module dma_w1c_status #(
   parameter int N = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] stat_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) stat_o <= '0;
      else        stat_o <= (stat_o & ~clr_i) | set_i;
   end

   for (genvar b = 0; b < N; b++) begin : g_chk
      // R8: a set in the same cycle as a clear leaves the bit set
      a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[b] |=> stat_o[b]);
      // R5: a lone write-1 clears the bit
      a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[b] && !set_i[b]) |=> !stat_o[b]);
   end
endmodule

// File: rtl/dma_ch_regs.sv
module dma_ch_regs
   import dma_regfile_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_sel,
   input  ch_word_e      wr_word,
   input  logic [DW-1:0] wdata,
   input  logic          done_pulse,
   output logic [DW-1:0] src_o,
   output logic [DW-1:0] dst_o,
   output logic [DW-1:0] ctrl0_o,
   output logic [DW-1:0] ctrl1_o
);
   logic wr_c0;
   assign wr_c0 = wr_sel && (wr_word == W_CTL0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_o   <= '0;
         dst_o   <= '0;
         ctrl0_o <= '0;
         ctrl1_o <= '0;
      end else begin
         if (wr_sel && wr_word == W_SRC)  src_o   <= wdata;
         if (wr_sel && wr_word == W_DST)  dst_o   <= wdata;
         if (wr_sel && wr_word == W_CTL1) ctrl1_o <= wdata & CTRL1_WMASK;
         if (wr_c0)           ctrl0_o <= wdata & CTRL0_WMASK;
         else if (done_pulse) ctrl0_o[EN_BIT] <= 1'b0;
      end
   end

   // R11: completion without a competing write drops the enable bit
   a_r11_enable_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (done_pulse && !wr_c0) |=> !ctrl0_o[EN_BIT]);
   // R11: a write in the completion cycle keeps the written enable value
   a_r11_write_priority: assert property (@(posedge clk) disable iff (!rst_n)
      (done_pulse && wr_c0) |=> (ctrl0_o[EN_BIT] == $past(wdata[EN_BIT])));
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
   import dma_regfile_pkg::*;
#(
   parameter int         NUM_CH = 16,
   parameter int         ADDR_W = 12,
   parameter logic [1:0] HW_VER = 2'd1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [DW-1:0]         wdata,
   output logic [DW-1:0]         rdata,
   input  logic [NUM_CH*CUR_W-1:0] eng_cur_cnt,
   input  logic [NUM_CH-1:0]     eng_done,
   input  logic [NUM_CH-1:0]     eng_unmask,
   output logic [NUM_CH*DW-1:0]  ch_src_o,
   output logic [NUM_CH*DW-1:0]  ch_dst_o,
   output logic [NUM_CH*DW-1:0]  ch_ctrl0_o,
   output logic [NUM_CH*DW-1:0]  ch_ctrl1_o,
   output logic                  arb_rr_o,
   output logic                  irq
);
   localparam int CH_IDX_W = $clog2(NUM_CH);
   localparam int WIN_LSB  = CH_IDX_W + 4;
   localparam logic [1:0] CH_CODE = 2'($clog2(NUM_CH / 8));

   if (!(NUM_CH == 8 || NUM_CH == 16 || NUM_CH == 32))
      $error("NUM_CH must be 8, 16 or 32");
   if (ADDR_W < 10)
      $error("ADDR_W must reach the global registers");

   logic [DW-1:0]       src_a   [NUM_CH];
   logic [DW-1:0]       dst_a   [NUM_CH];
   logic [DW-1:0]       ctrl0_a [NUM_CH];
   logic [DW-1:0]       ctrl1_a [NUM_CH];
   logic [CUR_W-1:0]    cur_a   [NUM_CH];
   logic [NUM_CH-1:0]   ie_v;
   logic [NUM_CH-1:0]   done_stat, unmask_stat;
   logic [NUM_CH-1:0]   done_clr, unmask_clr;
   logic                in_win;
   logic [CH_IDX_W-1:0] sel_ch;
   ch_word_e            sel_word;
   logic                hit_done, hit_unmask, hit_cfg;
   logic                rr_q;

   assign in_win     = (addr[ADDR_W-1:WIN_LSB] == '0);
   assign sel_ch     = addr[WIN_LSB-1:4];
   assign sel_word   = ch_word_e'(addr[3:2]);
   assign hit_done   = (addr == ADDR_W'(DONE_OFS));
   assign hit_unmask = (addr == ADDR_W'(UNMASK_OFS));
   assign hit_cfg    = (addr == ADDR_W'(CFG_OFS));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dma_ch_regs u_ch (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr_sel     (wr_en && in_win && (sel_ch == CH_IDX_W'(c))),
         .wr_word    (sel_word),
         .wdata      (wdata),
         .done_pulse (eng_done[c]),
         .src_o      (src_a[c]),
         .dst_o      (dst_a[c]),
         .ctrl0_o    (ctrl0_a[c]),
         .ctrl1_o    (ctrl1_a[c])
      );
      assign ch_src_o  [c*DW +: DW] = src_a[c];
      assign ch_dst_o  [c*DW +: DW] = dst_a[c];
      assign ch_ctrl0_o[c*DW +: DW] = ctrl0_a[c];
      assign ch_ctrl1_o[c*DW +: DW] = ctrl1_a[c];
      assign cur_a[c] = eng_cur_cnt[c*CUR_W +: CUR_W];
      assign ie_v[c]  = ctrl0_a[c][IE_BIT];

      // R6: a completion bit only rises after an enabled completion pulse
      a_r6_set_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(done_stat[c]) |-> $past(eng_done[c] && ie_v[c]));
   end

   assign done_clr   = (wr_en && hit_done)   ? wdata[NUM_CH-1:0] : '0;
   assign unmask_clr = (wr_en && hit_unmask) ? wdata[NUM_CH-1:0] : '0;

   dma_w1c_status #(.N(NUM_CH)) u_done (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (eng_done & ie_v),
      .clr_i  (done_clr),
      .stat_o (done_stat)
   );

   dma_w1c_status #(.N(NUM_CH)) u_unmask (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (eng_unmask),
      .clr_i  (unmask_clr),
      .stat_o (unmask_stat)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                 rr_q <= 1'b0;
      else if (wr_en && hit_cfg)  rr_q <= wdata[0];
   end

   assign arb_rr_o = rr_q;
   assign irq      = |done_stat;

   always_comb begin
      rdata = '0;
      if (in_win) begin
         unique case (sel_word)
            W_SRC:  rdata = src_a[sel_ch];
            W_DST:  rdata = dst_a[sel_ch];
            W_CTL0: begin
               rdata = ctrl0_a[sel_ch];
               rdata[CUR_LSB +: CUR_W] = cur_a[sel_ch];
            end
            W_CTL1: rdata = ctrl1_a[sel_ch];
         endcase
      end else if (hit_done) begin
         rdata = DW'(done_stat);
      end else if (hit_unmask) begin
         rdata = DW'(unmask_stat);
      end else if (hit_cfg) begin
         rdata = {27'd0, CH_CODE, HW_VER, rr_q};
      end
   end

   // R7: the interrupt drops one cycle after the last completion bit is cleared
   a_r7_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && ((done_stat & ~done_clr) == '0) && ((eng_done & ie_v) == '0)) |=> !irq);
endmodule

// File: tb/dma_regfile_test.sv
`timescale 1ns/1ps
module dma_regfile_test;
   localparam int NCH = 16;
   localparam int AW  = 12;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic [AW-1:0]   addr = '0;
   logic [31:0]     wdata = '0;
   logic [31:0]     rdata;
   logic [NCH*8-1:0] eng_cur_cnt = '0;
   logic [NCH-1:0]  eng_done = '0;
   logic [NCH-1:0]  eng_unmask = '0;
   logic [NCH*32-1:0] ch_src_o, ch_dst_o, ch_ctrl0_o, ch_ctrl1_o;
   logic            arb_rr_o, irq;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;
   bit cmp_on = 0;

   always #2 clk = ~clk;

   dma_regfile #(.NUM_CH(NCH), .ADDR_W(AW), .HW_VER(2'd1)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .eng_cur_cnt(eng_cur_cnt), .eng_done(eng_done),
      .eng_unmask(eng_unmask), .ch_src_o(ch_src_o), .ch_dst_o(ch_dst_o),
      .ch_ctrl0_o(ch_ctrl0_o), .ch_ctrl1_o(ch_ctrl1_o), .arb_rr_o(arb_rr_o),
      .irq(irq));

   // behavioural reference state
   logic [31:0] m_src [NCH];
   logic [31:0] m_dst [NCH];
   logic [31:0] m_c0  [NCH];
   logic [31:0] m_c1  [NCH];
   logic [NCH-1:0] m_done, m_unm;
   logic m_rr;

   function automatic int win_ch(input logic [AW-1:0] a);
      return (a < 12'h100) ? int'(a >> 4) : -1;
   endfunction

   function automatic logic [31:0] model_read(input logic [AW-1:0] a);
      int c = win_ch(a);
      if (c >= 0) begin
         case (a[3:2])
            2'd0: return m_src[c];
            2'd1: return m_dst[c];
            2'd2: return m_c0[c] | (32'(eng_cur_cnt[c*8 +: 8]) << 8);
            default: return m_c1[c];
         endcase
      end
      if (a == 12'h204) return 32'(m_done);
      if (a == 12'h200) return 32'(m_unm);
      if (a == 12'h220) return {27'd0, 2'd1, 2'd1, m_rr};
      return 32'd0;
   endfunction

   function automatic string region(input logic [AW-1:0] a);
      int c = win_ch(a);
      if (c >= 0) return (a[3:2] == 2'd2) ? "R3" : (a[3:2] == 2'd3) ? "R4" : "R2";
      if (a == 12'h204) return "R5";
      if (a == 12'h200) return "R9";
      if (a == 12'h220) return "R10";
      return "R12";
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            m_src[c] = 0; m_dst[c] = 0; m_c0[c] = 0; m_c1[c] = 0;
         end
         m_done = '0; m_unm = '0; m_rr = 1'b0;
      end else begin
         logic [NCH-1:0] setd;
         int wc;
         for (int c = 0; c < NCH; c++) setd[c] = eng_done[c] & m_c0[c][2];
         m_done = (m_done & ~((wr_en && addr == 12'h204) ? wdata[NCH-1:0] : '0)) | setd;
         m_unm  = (m_unm  & ~((wr_en && addr == 12'h200) ? wdata[NCH-1:0] : '0)) | eng_unmask;
         for (int c = 0; c < NCH; c++) if (eng_done[c]) m_c0[c][1] = 1'b0;
         wc = win_ch(addr);
         if (wr_en && wc >= 0) begin
            case (addr[3:2])
               2'd0: m_src[wc] = wdata;
               2'd1: m_dst[wc] = wdata;
               2'd2: m_c0[wc]  = wdata & 32'hFFFF_00FF;
               default: m_c1[wc] = wdata & 32'h03FF_7FFF;
            endcase
         end
         if (wr_en && addr == 12'h220) m_rr = wdata[0];
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (cmp_on && rst_n && !finished) begin
         check({region(addr), " read"}, rdata, model_read(addr));
         check("R7 irq", 32'(irq), 32'(|m_done));
         check("R10 arb", 32'(arb_rr_o), 32'(m_rr));
         for (int c = 0; c < NCH; c++) begin
            check("R2 src out", ch_src_o[c*32 +: 32], m_src[c]);
            check("R2 dst out", ch_dst_o[c*32 +: 32], m_dst[c]);
            check("R3 ctrl0 out", ch_ctrl0_o[c*32 +: 32], m_c0[c]);
            check("R4 ctrl1 out", ch_ctrl1_o[c*32 +: 32], m_c1[c]);
         end
      end
   end

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
      addr = a; #0.5;
      check(tag, rdata, exp);
   endtask

   task automatic pulse_done(input logic [NCH-1:0] m);
      eng_done = m; tick(); eng_done = '0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #800000;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1: reset state
      check("R1 irq", 32'(irq), 0);
      rd_chk("R1 done", 12'h204, 0);
      rd_chk("R1 unmask", 12'h200, 0);
      rd_chk("R1 cfg", 12'h220, 32'h0000_000A);
      rd_chk("R1 ch0 src", 12'h000, 0);
      rd_chk("R1 ch15 ctrl1", 12'h0FC, 0);
      cmp_on = 1;

      for (int c = 0; c < NCH; c++) begin
         wr(AW'(c*16 + 0), 32'hA000_0000 + 32'(c));
         wr(AW'(c*16 + 4), 32'hB000_0000 + 32'(c * 3));
         wr(AW'(c*16 + 12), 32'hFFFF_FFFF ^ 32'(c));
      end
      rd_chk("R2 ch7 dst", 12'h074, 32'hB000_0015);
      rd_chk("R4 ch0 ctrl1 mask", 12'h00C, 32'h03FF_7FFF);

      // R3: current-count field is live and not writable
      eng_cur_cnt[2*8 +: 8] = 8'h5A;
      wr(12'h028, 32'hFFFF_FFFF);
      rd_chk("R3 ctrl0 live count", 12'h028, 32'hFFFF_5AFF);
      check("R3 ctrl0 out count zero", ch_ctrl0_o[2*32 +: 32], 32'hFFFF_00FF);

      // R6: completion without done-interrupt enable does not set status
      wr(12'h038, 32'h0000_0002);
      pulse_done(16'h0008);
      rd_chk("R6 no ie no status", 12'h204, 0);
      check("R6 irq stays low", 32'(irq), 0);
      rd_chk("R11 enable dropped", 12'h038, 32'h0000_0000);

      // R6/R7: enabled completion sets status and irq
      wr(12'h058, 32'h0000_0006);
      pulse_done(16'h0020);
      rd_chk("R6 status set", 12'h204, 32'h0000_0020);
      check("R7 irq high", 32'(irq), 1);
      rd_chk("R11 enable cleared", 12'h058, 32'h0000_0004);

      // R5: write 0 keeps, write 1 clears
      wr(12'h204, 32'h0000_0000);
      rd_chk("R5 write0 keeps", 12'h204, 32'h0000_0020);
      wr(12'h204, 32'h0000_0020);
      rd_chk("R5 write1 clears", 12'h204, 0);
      check("R7 irq low", 32'(irq), 0);

      // R8: set and clear in the same cycle
      pulse_done(16'h0020);
      eng_done = 16'h0020; wr(12'h204, 32'h0000_0020); eng_done = '0;
      rd_chk("R8 set wins", 12'h204, 32'h0000_0020);

      // R11: write to ctrl0 in the completion cycle wins
      eng_done = 16'h0020; wr(12'h058, 32'h0000_0006); eng_done = '0;
      rd_chk("R11 write priority", 12'h058, 32'h0000_0006);

      // R9: unmask status independent of irq
      wr(12'h204, 32'hFFFF_FFFF);
      eng_unmask = 16'h0002; tick(); eng_unmask = '0;
      rd_chk("R9 unmask set", 12'h200, 32'h0000_0002);
      check("R9 no irq", 32'(irq), 0);
      wr(12'h200, 32'h0000_0002);
      rd_chk("R9 unmask cleared", 12'h200, 0);

      // R10: config word
      wr(12'h220, 32'hFFFF_FFFF);
      rd_chk("R10 cfg rr", 12'h220, 32'h0000_000B);
      check("R10 arb out", 32'(arb_rr_o), 1);
      wr(12'h220, 32'h0);
      rd_chk("R10 cfg clear", 12'h220, 32'h0000_000A);

      // R12: unmapped addresses
      wr(12'h100, 32'hDEAD_BEEF);
      wr(12'h208, 32'hDEAD_BEEF);
      rd_chk("R12 unmapped 0x100", 12'h100, 0);
      rd_chk("R12 unmapped 0x208", 12'h208, 0);
      rd_chk("R12 ch0 untouched", 12'h000, 32'hA000_0000);

      // mixed traffic, compared every cycle against the model
      for (int i = 0; i < 3000; i++) begin
         logic [AW-1:0] a;
         int k = $urandom_range(0, 9);
         if (k < 6)      a = AW'($urandom_range(0, 63) * 4);
         else if (k == 6) a = 12'h204;
         else if (k == 7) a = 12'h200;
         else if (k == 8) a = 12'h220;
         else            a = AW'($urandom_range(64, 200) * 4);
         wr_en = ($urandom_range(0, 2) == 0);
         addr  = a;
         wdata = $urandom;
         eng_done   = ($urandom_range(0, 3) == 0) ? NCH'($urandom) : '0;
         eng_unmask = ($urandom_range(0, 5) == 0) ? NCH'($urandom) : '0;
         eng_cur_cnt[($urandom_range(0, NCH-1))*8 +: 8] = 8'($urandom);
         tick();
      end
      wr_en = 0; eng_done = '0; eng_unmask = '0;
      for (int a = 0; a < 'h240; a += 4) begin
         addr = AW'(a);
         tick();
      end
      finish_run();
   end
endmodule